// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block is the receive side of a programmable asynchronous serial controller. A receive clock enable paces the receiver. The mode fields pick an oversampling factor of 1, 16 or 64 ticks per bit, a character of 5 to 8 bits, and an optional parity bit of either sense. The receiver detects a start bit on the serial line and, when oversampling, confirms that the bit is still low at its midpoint. It then samples each data bit, the parity bit and the stop bit at the bit centre.

A finished character goes into a holding register and raises a ready flag, which the CPU clears by reading the data. Parity, overrun and framing problems each set their own flag. These flags stay set until an error-reset pulse clears them, and reading the data does not touch them. While receive-enable is low the receiver stays idle and assembles nothing.

Top module: `serial_rx_core`

## Requirements
- R1: `len_sel` picks the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive LSB first. `rx_data` bits above the chosen length read as 0.
- R2: With `par_en` high, one parity bit follows the data. With `par_even` high, data plus parity must hold an even number of ones; with it low, an odd number. A mismatch sets `par_err`. With `par_en` low, no parity bit is expected and `par_err` is never set.
- R3: A stop bit sampled as 0 sets `frm_err`. The character is still stored.
- R4: Storing a character sets `rx_ready` one cycle after the stop-bit sample. A `data_rd` pulse clears `rx_ready`. If a store and a read fall in the same cycle, the store wins. After reset `rx_ready` is 0 and `rx_data` is 0.
- R5: `par_err`, `ovr_err` and `frm_err` stay set until an `err_clr` pulse. An error detected in the same cycle as `err_clr` stays set. `data_rd` does not affect these flags.
- R6: While `rx_en` is low no character is assembled or stored. Dropping `rx_en` in the middle of a character abandons that character.
- R7: A character that completes while `rx_ready` is still set replaces `rx_data` and sets `ovr_err`.
- R8: `baud_sel` 2 selects 16x and 3 selects 64x. In these modes, a low seen on an idle line must still be low F/2 ticks later, or it is dropped as a false start. Each later bit is sampled F ticks after the previous sample.
- R9: `baud_sel` 1 selects 1x. Each tick samples one bit, and there is no start-bit check. `baud_sel` 0 behaves as 1x.
- R10: The receiver samples `rxd` and advances only on cycles with `rx_tick` high. The line value on other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_tick | input | 1 | Receive clock enable, one oversampling tick |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| baud_sel | input | 2 | Oversampling factor: 0/1 = 1x, 2 = 16x, 3 = 64x |
| len_sel | input | 2 | Character length: 5 + len_sel bits |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| err_clr | input | 1 | Pulse: clear the three error flags |
| data_rd | input | 1 | Pulse: the CPU read the character |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Character waiting |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| frm_err | output | 1 | Sticky framing error |

## Verification
The bench builds the block with its default parameters: 8 data bits at most, and oversampling factors of 16 and 64. All three factors and both 1x encodings are therefore run at full frame length, including the 64x midpoint check. Between ticks, and during gaps of random length, the bench drives noise on the line to show that only tick cycles are sampled. A short low pulse tests false-start rejection. A frame cut off by `rx_en` tests recovery.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    localparam logic [1:0] BAUD_16X = 2'b10;
    localparam logic [1:0] BAUD_64X = 2'b11;

endpackage

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int MAX_BITS = 8,
    parameter int OSR_MID  = 16,
    parameter int OSR_HIGH = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_tick,
    input  logic                rxd,
    input  logic                rx_en,
    input  logic [1:0]          baud_sel,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    input  logic                par_even,
    output logic                frame_done,
    output logic [MAX_BITS-1:0] frame_word,
    output logic                frame_par_bad,
    output logic                frame_stop_bad
);

    localparam int CNT_W    = $clog2(OSR_HIGH);
    localparam int IDX_W    = $clog2(MAX_BITS);
    localparam int MIN_BITS = MAX_BITS - 3;

    typedef struct packed {
        rx_state_e           state;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [MAX_BITS-1:0] shreg;
        logic                pbit;
        logic                done;
        logic                par_bad;
        logic                stop_bad;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;

    logic [CNT_W-1:0] full_lim_d, half_lim_d;
    logic             one_x_d;
    logic [IDX_W-1:0] last_idx_d;

    always_comb begin
        one_x_d    = 1'b0;
        full_lim_d = '0;
        half_lim_d = '0;
        case (baud_sel)
            BAUD_16X: begin
                full_lim_d = CNT_W'(OSR_MID - 1);
                half_lim_d = CNT_W'(OSR_MID / 2 - 1);
            end
            BAUD_64X: begin
                full_lim_d = CNT_W'(OSR_HIGH - 1);
                half_lim_d = CNT_W'(OSR_HIGH / 2 - 1);
            end
            default: one_x_d = 1'b1;
        endcase
        last_idx_d = IDX_W'(MIN_BITS - 1) + IDX_W'(len_sel);
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!rx_en) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
        end else if (rx_tick) begin
            case (r_q.state)
                ST_IDLE: begin
                    if (!rxd) begin
                        r_d.shreg = '0;
                        r_d.idx   = '0;
                        r_d.cnt   = '0;
                        r_d.state = one_x_d ? ST_DATA : ST_START;
                    end
                end
                ST_START: begin
                    if (r_q.cnt == half_lim_d) begin
                        r_d.cnt   = '0;
                        r_d.state = rxd ? ST_IDLE : ST_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (r_q.cnt != full_lim_d) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else begin
                        r_d.cnt = '0;
                        case (r_q.state)
                            ST_DATA: begin
                                r_d.shreg[r_q.idx] = rxd;
                                if (r_q.idx == last_idx_d) begin
                                    r_d.state = par_en ? ST_PAR : ST_STOP;
                                end else begin
                                    r_d.idx = r_q.idx + 1'b1;
                                end
                            end
                            ST_PAR: begin
                                r_d.pbit  = rxd;
                                r_d.state = ST_STOP;
                            end
                            default: begin
                                r_d.done     = 1'b1;
                                r_d.stop_bad = ~rxd;
                                r_d.par_bad  = par_en & ((^r_q.shreg) ^ r_q.pbit ^ ~par_even);
                                r_d.state    = ST_IDLE;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_done     = r_q.done;
    assign frame_word     = r_q.shreg;
    assign frame_par_bad  = r_q.par_bad;
    assign frame_stop_bad = r_q.stop_bad;

    // R1: a delivered word carries nothing above the selected length
    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ((frame_word >> (4'(MIN_BITS) + 4'(len_sel))) == '0));

    // R6: receive disabled means no character can come out
    assert_no_frame_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !frame_done);

    // R10: without a tick the sequencer holds its place
    assert_tick_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_tick && rx_en) |=> ($stable(r_q.state) && !frame_done));

endmodule

// File: rtl/srx_holding.sv
module srx_holding #(
    parameter int MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  logic [MAX_BITS-1:0] frame_word,
    input  logic                frame_par_bad,
    input  logic                frame_stop_bad,
    input  logic                data_rd,
    input  logic                err_clr,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_ready,
    output logic                par_err,
    output logic                ovr_err,
    output logic                frm_err
);

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                ready;
        logic                perr;
        logic                oerr;
        logic                ferr;
    } hold_regs_t;

    hold_regs_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        if (err_clr) begin
            h_d.perr = 1'b0;
            h_d.oerr = 1'b0;
            h_d.ferr = 1'b0;
        end
        if (data_rd) begin
            h_d.ready = 1'b0;
        end
        if (frame_done) begin
            h_d.data  = frame_word;
            h_d.ready = 1'b1;
            h_d.oerr  = h_d.oerr | (h_q.ready & ~data_rd);
            h_d.perr  = h_d.perr | frame_par_bad;
            h_d.ferr  = h_d.ferr | frame_stop_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign rx_data  = h_q.data;
    assign rx_ready = h_q.ready;
    assign par_err  = h_q.perr;
    assign ovr_err  = h_q.oerr;
    assign frm_err  = h_q.ferr;

    assert_ready_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rx_ready);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !frame_done) |=> !rx_ready);

    assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_ready && !data_rd) |=> ovr_err);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((!$past(par_err) || par_err) && (!$past(ovr_err) || ovr_err)
                      && (!$past(frm_err) || frm_err)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !frame_done) |=> (!par_err && !ovr_err && !frm_err));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
    parameter int MAX_BITS = 8,
    parameter int OSR_MID  = 16,
    parameter int OSR_HIGH = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_tick,
    input  logic                rxd,
    input  logic                rx_en,
    input  logic [1:0]          baud_sel,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                err_clr,
    input  logic                data_rd,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_ready,
    output logic                par_err,
    output logic                ovr_err,
    output logic                frm_err
);

    logic                frame_done;
    logic [MAX_BITS-1:0] frame_word;
    logic                frame_par_bad;
    logic                frame_stop_bad;

    srx_frame_fsm #(
        .MAX_BITS (MAX_BITS),
        .OSR_MID  (OSR_MID),
        .OSR_HIGH (OSR_HIGH)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_tick        (rx_tick),
        .rxd            (rxd),
        .rx_en          (rx_en),
        .baud_sel       (baud_sel),
        .len_sel        (len_sel),
        .par_en         (par_en),
        .par_even       (par_even),
        .frame_done     (frame_done),
        .frame_word     (frame_word),
        .frame_par_bad  (frame_par_bad),
        .frame_stop_bad (frame_stop_bad)
    );

    srx_holding #(
        .MAX_BITS (MAX_BITS)
    ) u_hold (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_done     (frame_done),
        .frame_word     (frame_word),
        .frame_par_bad  (frame_par_bad),
        .frame_stop_bad (frame_stop_bad),
        .data_rd        (data_rd),
        .err_clr        (err_clr),
        .rx_data        (rx_data),
        .rx_ready       (rx_ready),
        .par_err        (par_err),
        .ovr_err        (ovr_err),
        .frm_err        (frm_err)
    );

endmodule

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] baud_sel = 2'b01;
    logic [1:0] len_sel = 2'b11;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       err_clr = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, par_err, ovr_err, frm_err;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] exp_data = '0;
    logic       exp_ready = 1'b0, exp_pe = 1'b0, exp_oe = 1'b0, exp_fe = 1'b0;

    serial_rx_core dut (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd), .rx_en(rx_en),
        .baud_sel(baud_sel), .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
        .err_clr(err_clr), .data_rd(data_rd), .rx_data(rx_data), .rx_ready(rx_ready),
        .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] len_mask(input logic [1:0] ls);
        return 8'hFF >> (3 - ls);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        chk(rx_data == exp_data, {tag, " data"}, rx_data, exp_data);
        chk(rx_ready == exp_ready, {tag, " ready R4"}, 8'(rx_ready), 8'(exp_ready));
        chk(par_err == exp_pe, {tag, " parity R2"}, 8'(par_err), 8'(exp_pe));
        chk(ovr_err == exp_oe, {tag, " overrun R7"}, 8'(ovr_err), 8'(exp_oe));
        chk(frm_err == exp_fe, {tag, " framing R3"}, 8'(frm_err), 8'(exp_fe));
    endtask

    // one receive tick; noise on the line between ticks (R10)
    task automatic tick(input logic b);
        @(negedge clk);
        rxd = b;
        rx_tick = 1'b1;
        @(negedge clk);
        rx_tick = 1'b0;
        rxd = 1'($urandom);
        repeat ($urandom % 3) begin
            @(negedge clk);
            rxd = 1'($urandom);
        end
    endtask

    function automatic int factor_of(input logic [1:0] bs);
        return (bs == 2'b10) ? 16 : (bs == 2'b11) ? 64 : 1;
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_v);
        int f;
        logic [7:0] m;
        f = factor_of(baud_sel);
        m = d & len_mask(len_sel);
        repeat (f) tick(1'b0);
        for (int i = 0; i < 5 + int'(len_sel); i++) repeat (f) tick(d[i]);
        if (par_en) repeat (f) tick(par_bit(m, par_even) ^ flip_par);
        repeat (f) tick(stop_v);
        repeat (f + 2) tick(1'b1);
        if (rx_en) begin
            exp_oe    = exp_oe | exp_ready;
            exp_ready = 1'b1;
            exp_data  = m;
            exp_pe    = exp_pe | (par_en & flip_par);
            exp_fe    = exp_fe | ~stop_v;
        end
    endtask

    task automatic do_read();
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
        exp_ready = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        exp_pe = 1'b0;
        exp_oe = 1'b0;
        exp_fe = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("reset R4");

        // 1x through encoding 0, 8 bits, no parity
        baud_sel = 2'b00; len_sel = 2'b11; par_en = 1'b0;
        send_frame(8'hA5, 1'b0, 1'b1);
        check_all("1x enc0 R9 R10 R1");
        do_read();
        check_all("read clears R4");

        // 16x false start then a real frame
        baud_sel = 2'b10;
        repeat (4) tick(1'b0);
        repeat (20) tick(1'b1);
        check_all("false start dropped R8");
        send_frame(8'h3C, 1'b0, 1'b1);
        check_all("16x frame after glitch R8");
        do_read();

        // parity: even good, even bad, odd good
        par_en = 1'b1; par_even = 1'b1; len_sel = 2'b10;
        send_frame(8'h55, 1'b0, 1'b1);
        check_all("even parity ok R2");
        do_read();
        send_frame(8'h17, 1'b1, 1'b1);
        check_all("even parity bad R2");
        do_read();
        par_even = 1'b0;
        send_frame(8'h0E, 1'b0, 1'b1);
        check_all("odd parity ok, flag sticky R2 R5");
        do_read();

        // framing
        par_en = 1'b0; baud_sel = 2'b01;
        send_frame(8'h81, 1'b0, 1'b0);
        check_all("stop low R3");

        // overrun without reading
        send_frame(8'h42, 1'b0, 1'b1);
        check_all("overrun R7");
        do_read();
        check_all("read keeps flags R5");
        do_clear();
        check_all("err clear R5");

        // receive disabled
        rx_en = 1'b0;
        send_frame(8'hF0, 1'b0, 1'b1);
        check_all("disabled ignored R6");

        // abandon mid-frame, then a clean frame
        rx_en = 1'b1;
        tick(1'b0); tick(1'b0); tick(1'b1); tick(1'b0);
        @(negedge clk) rx_en = 1'b0;
        repeat (3) tick(1'b1);
        @(negedge clk) rx_en = 1'b1;
        repeat (3) tick(1'b1);
        check_all("abandoned frame R6");
        send_frame(8'h6B, 1'b0, 1'b1);
        check_all("frame after abandon R6");
        do_read();

        // 64x, 5 bits, upper bits zero
        baud_sel = 2'b11; len_sel = 2'b00;
        send_frame(8'hFF, 1'b0, 1'b1);
        check_all("64x 5-bit upper zero R8 R1");
        do_read();

        // random frames
        for (int k = 0; k < 30; k++) begin
            baud_sel = ($urandom % 3 == 0) ? 2'b10 : 2'($urandom % 2);
            len_sel  = 2'($urandom);
            par_en   = 1'($urandom);
            par_even = 1'($urandom);
            send_frame(8'($urandom), par_en & (($urandom % 4) == 0), ($urandom % 6) != 0);
            check_all("random R1 R2 R3 R9 R10");
            if ($urandom % 2 == 0) do_read();
            if ($urandom % 4 == 0) do_clear();
            check_all("random after rd/clr R4 R5 R7");
        end

        finish_run();
    end

endmodule